// File: doc/BRIEF.md
# Stall-Credited Transaction Latency Monitor

This block watches transfers inside a pipelined memory controller and measures how long each one spends there. The raw flight time runs from the cycle a transfer is accepted to the cycle its data goes back to the requester. Cycles lost to contention are taken out of that time: a cycle held at a pipeline stage for lack of downstream space, or a cycle spent waiting at an arbiter. What remains is the adjusted latency. It reflects the controller's intrinsic delay, so it can be compared against an architectural bound.

Up to eight transfers can be in flight at once, one per 3-bit tag. Every stage and every arbiter drives one stall bit per tag. Each completed transfer produces a one-cycle report with its class and adjusted latency, plus a violation flag when the result exceeds that class's bound. For each of the four classes the block keeps the smallest and largest adjusted latency seen. The bounds can be rewritten only while no transfer is in flight. A synchronous clear empties the min/max records.

Top module: `xfer_lat_monitor`

## Requirements
- R1: A transfer whose start is sampled on clock edge s and whose done is sampled on edge d has raw latency d-s. Its report (`rpt_vld`=1 with `rpt_lat` and `rpt_kind`) is visible right after edge d, for one cycle.
- R2: Every stall bit `stage_stall[st*8+id]` that is high on an edge strictly between s and d adds one credit to tag id. Adjusted latency = raw latency minus credits.
- R3: Every wait bit `arb_wait[a*8+id]` that is high on an edge strictly between s and d also adds one credit to tag id. Several bits high on the same edge each count.
- R4: Stall and wait bits for other tags, and arbiter bits for paths a transfer does not use, add nothing to that transfer's credit.
- R5: The class given with the start (0 program fetch, 1 data access, 2 DMA, 3 coherence operation) is returned on `rpt_kind` with the report.
- R6: `viol` is high together with a report exactly when the adjusted latency is strictly greater than the bound of the report's class. Otherwise it is low.
- R7: For each class k, `min_lat[k*16+:16]` and `max_lat[k*16+:16]` hold the smallest and largest adjusted latency reported since reset or clear. They are updated on the report's edge. After reset they read 16'hFFFF and 0.
- R8: A write (`lim_we`, `lim_sel`, `lim_val`) sets a class bound only on an edge where no tag is in flight. A write while any tag is busy is ignored. Bounds reset to 16'hFFFF.
- R9: `stats_clr` sampled high sets every min to 16'hFFFF and every max to 0 on that edge. It takes precedence over an update on the same edge.
- R10: A start on a tag already in flight is ignored: the original start cycle and class stay. A done on an idle tag produces no report.
- R11: The flight-time and credit counters saturate at 16'hFFFF instead of wrapping.
- R12: When credits exceed the raw latency, the adjusted latency is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_vld | input | 1 | A transfer enters the controller this cycle |
| start_id | input | 3 | Tag of the entering transfer |
| start_kind | input | 2 | Class of the entering transfer |
| done_vld | input | 1 | A transfer's data is returned this cycle |
| done_id | input | 3 | Tag of the finishing transfer |
| stage_stall | input | 32 | Per-stage, per-tag hold bits, index stage*8+tag |
| arb_wait | input | 16 | Per-arbiter, per-tag wait bits, index arbiter*8+tag |
| lim_we | input | 1 | Bound write strobe |
| lim_sel | input | 2 | Class whose bound is written |
| lim_val | input | 16 | New bound value |
| stats_clr | input | 1 | Synchronous clear of min/max records |
| rpt_vld | output | 1 | Completion report valid |
| rpt_kind | output | 2 | Class of the reported transfer |
| rpt_lat | output | 16 | Adjusted latency of the reported transfer |
| viol | output | 1 | Reported latency exceeds its class bound |
| min_lat | output | 64 | Per-class smallest adjusted latency, class k at k*16 |
| max_lat | output | 64 | Per-class largest adjusted latency, class k at k*16 |

## Verification
The report, the violation flag and the min/max records all change on the very edge that samples the done event. A bound write or a clear takes effect on the edge that samples it. The bench drives inputs 5 ns after a rising edge and advances a behavioural model on each rising edge. It compares every output against the model on the following falling edge, so each result is read in the cycle it is first due. The directed scenarios add hand-computed latencies, which are read right after the done edge before any new stimulus.

// File: rtl/xlm_pkg.sv
package xlm_pkg;

  localparam int unsigned LAT_W_DEF  = 16;
  localparam int unsigned NSLOT_DEF  = 8;
  localparam int unsigned NKIND_DEF  = 4;
  localparam int unsigned NSTAGE_DEF = 4;
  localparam int unsigned NARB_DEF   = 2;

  typedef enum logic [1:0] {
    KIND_PFETCH = 2'd0,
    KIND_DACC   = 2'd1,
    KIND_DMA    = 2'd2,
    KIND_COH    = 2'd3
  } xfer_kind_e;

endpackage

// File: rtl/xlm_slot.sv
module xlm_slot #(
  parameter int unsigned LAT_W  = xlm_pkg::LAT_W_DEF,
  parameter int unsigned NSRC   = 6,
  parameter int unsigned KIND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_hit,
  input  logic              done_hit,
  input  logic [NSRC-1:0]   stall_bits,
  input  logic [KIND_W-1:0] start_kind,
  output logic              busy,
  output logic [KIND_W-1:0] kind,
  output logic [LAT_W-1:0]  adj_lat
);

  localparam int unsigned PC_W = $clog2(NSRC + 1);
  localparam logic [LAT_W-1:0] LAT_MAX = '1;

  logic              busy_q, busy_d;
  logic [LAT_W-1:0]  cnt_q, cnt_d;
  logic [LAT_W-1:0]  cred_q, cred_d;
  logic [KIND_W-1:0] kind_q, kind_d;
  logic [PC_W-1:0]   pc;
  logic [LAT_W:0]    cred_sum;
  logic [LAT_W-1:0]  raw;
  logic              en;

  always_comb begin
    pc = '0;
    for (int i = 0; i < NSRC; i++) begin
      pc = pc + PC_W'(stall_bits[i]);
    end
  end

  assign cred_sum = {1'b0, cred_q} + (LAT_W + 1)'(pc);
  assign en       = busy_q | start_hit;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cred_d = cred_q;
    kind_d = kind_q;
    if (busy_q) begin
      if (done_hit) begin
        busy_d = 1'b0;
      end else begin
        cnt_d  = (cnt_q == LAT_MAX) ? cnt_q : cnt_q + 1'b1;
        cred_d = cred_sum[LAT_W] ? LAT_MAX : cred_sum[LAT_W-1:0];
      end
    end else if (start_hit) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      cred_d = '0;
      kind_d = start_kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cred_q <= '0;
      kind_q <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      cred_q <= cred_d;
      kind_q <= kind_d;
    end
  end

  assign raw     = (cnt_q == LAT_MAX) ? LAT_MAX : cnt_q + 1'b1;
  assign adj_lat = (raw > cred_q) ? raw - cred_q : '0;
  assign busy    = busy_q;
  assign kind    = kind_q;

  // R10: an in-flight tag stays busy until its own done arrives
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done_hit |=> busy_q);

  // R10: a repeated start does not change the stored class
  a_r10_kind_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done_hit |=> $stable(kind_q));

  // R11: flight time stays pinned at its ceiling
  a_r11_cnt_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done_hit && cnt_q == LAT_MAX |=> cnt_q == LAT_MAX);

  // R11: credit stays pinned at its ceiling
  a_r11_cred_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done_hit && cred_q == LAT_MAX |=> cred_q == LAT_MAX);

endmodule

// File: rtl/xlm_kind_stats.sv
module xlm_kind_stats #(
  parameter int unsigned LAT_W = xlm_pkg::LAT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic [LAT_W-1:0] lat_in,
  input  logic             lim_we,
  input  logic [LAT_W-1:0] lim_in,
  output logic [LAT_W-1:0] min_lat,
  output logic [LAT_W-1:0] max_lat,
  output logic [LAT_W-1:0] limit
);

  logic [LAT_W-1:0] min_q, min_d, max_q, max_d, lim_q;
  logic             rec_en;

  assign rec_en = clr | upd;

  always_comb begin
    min_d = min_q;
    max_d = max_q;
    if (clr) begin
      min_d = '1;
      max_d = '0;
    end else if (upd) begin
      if (lat_in < min_q) min_d = lat_in;
      if (lat_in > max_q) max_d = lat_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '1;
      max_q <= '0;
    end else if (rec_en) begin
      min_q <= min_d;
      max_q <= max_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '1;
    end else if (lim_we) begin
      lim_q <= lim_in;
    end
  end

  assign min_lat = min_q;
  assign max_lat = max_q;
  assign limit   = lim_q;

  // R7: once a nonzero maximum is recorded, the minimum never exceeds it
  a_r7_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
    (max_q != '0) |-> (min_q <= max_q));

  // R9: a clear leaves the record empty on the next cycle
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (min_q == '1) && (max_q == '0));

endmodule

// File: rtl/xfer_lat_monitor.sv
module xfer_lat_monitor #(
  parameter int unsigned NSLOT  = xlm_pkg::NSLOT_DEF,
  parameter int unsigned NKIND  = xlm_pkg::NKIND_DEF,
  parameter int unsigned NSTAGE = xlm_pkg::NSTAGE_DEF,
  parameter int unsigned NARB   = xlm_pkg::NARB_DEF,
  parameter int unsigned LAT_W  = xlm_pkg::LAT_W_DEF,
  localparam int unsigned ID_W   = $clog2(NSLOT),
  localparam int unsigned KIND_W = $clog2(NKIND)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_vld,
  input  logic [ID_W-1:0]         start_id,
  input  logic [KIND_W-1:0]       start_kind,
  input  logic                    done_vld,
  input  logic [ID_W-1:0]         done_id,
  input  logic [NSTAGE*NSLOT-1:0] stage_stall,
  input  logic [NARB*NSLOT-1:0]   arb_wait,
  input  logic                    lim_we,
  input  logic [KIND_W-1:0]       lim_sel,
  input  logic [LAT_W-1:0]        lim_val,
  input  logic                    stats_clr,
  output logic                    rpt_vld,
  output logic [KIND_W-1:0]       rpt_kind,
  output logic [LAT_W-1:0]        rpt_lat,
  output logic                    viol,
  output logic [NKIND*LAT_W-1:0]  min_lat,
  output logic [NKIND*LAT_W-1:0]  max_lat
);

  localparam int unsigned NSRC = NSTAGE + NARB;

  logic [NSLOT-1:0][NSRC-1:0]   slot_stall;
  logic [NSLOT-1:0]             start_hit, done_hit, busy_v;
  logic [NSLOT-1:0][KIND_W-1:0] kind_v;
  logic [NSLOT-1:0][LAT_W-1:0]  adj_v;
  logic [NKIND-1:0][LAT_W-1:0]  limit_v, min_v, max_v;
  logic                         any_busy, fin, over;
  logic [LAT_W-1:0]             sel_lat;
  logic [KIND_W-1:0]            sel_kind;

  // per-tag trackers
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stg
      assign slot_stall[g][s] = stage_stall[s*NSLOT + g];
    end
    for (genvar a = 0; a < NARB; a++) begin : g_arb
      assign slot_stall[g][NSTAGE + a] = arb_wait[a*NSLOT + g];
    end
    assign start_hit[g] = start_vld && (start_id == ID_W'(g));
    assign done_hit[g]  = done_vld  && (done_id  == ID_W'(g));

    xlm_slot #(
      .LAT_W (LAT_W),
      .NSRC  (NSRC),
      .KIND_W(KIND_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_hit (start_hit[g]),
      .done_hit  (done_hit[g]),
      .stall_bits(slot_stall[g]),
      .start_kind(start_kind),
      .busy      (busy_v[g]),
      .kind      (kind_v[g]),
      .adj_lat   (adj_v[g])
    );
  end

  assign any_busy = |busy_v;
  assign fin      = done_vld && busy_v[done_id];
  assign sel_lat  = adj_v[done_id];
  assign sel_kind = kind_v[done_id];
  assign over     = sel_lat > limit_v[sel_kind];

  // per-class records and bounds
  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    xlm_kind_stats #(
      .LAT_W(LAT_W)
    ) u_stats (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (stats_clr),
      .upd    (fin && (sel_kind == KIND_W'(k))),
      .lat_in (sel_lat),
      .lim_we (lim_we && !any_busy && (lim_sel == KIND_W'(k))),
      .lim_in (lim_val),
      .min_lat(min_v[k]),
      .max_lat(max_v[k]),
      .limit  (limit_v[k])
    );
    assign min_lat[k*LAT_W +: LAT_W] = min_v[k];
    assign max_lat[k*LAT_W +: LAT_W] = max_v[k];
  end

  // completion report register
  logic              rv_q, rv_d, vi_q, vi_d;
  logic [LAT_W-1:0]  rl_q, rl_d;
  logic [KIND_W-1:0] rk_q, rk_d;

  always_comb begin
    rv_d = fin;
    vi_d = fin && over;
    rl_d = fin ? sel_lat  : rl_q;
    rk_d = fin ? sel_kind : rk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      vi_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
      vi_q <= vi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_q <= '0;
      rk_q <= '0;
    end else if (fin) begin
      rl_q <= rl_d;
      rk_q <= rk_d;
    end
  end

  assign rpt_vld  = rv_q;
  assign viol     = vi_q;
  assign rpt_lat  = rl_q;
  assign rpt_kind = rk_q;

  // R1: a report only follows a sampled done
  a_r1_rpt_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld |-> $past(done_vld));

  // R6: a violation is only flagged with a report
  a_r6_viol_with_rpt: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> rpt_vld);

  // R8: bounds hold while any transfer is in flight
  a_r8_lim_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    any_busy |=> $stable(limit_v));

  // R10: a done on an idle tag yields no report
  a_r10_idle_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && !busy_v[done_id] |=> !rpt_vld);

endmodule

// File: tb/xfer_lat_monitor_tb.sv
module xfer_lat_monitor_tb;

  localparam int NSLOT = 8, NKIND = 4, NSTAGE = 4, NARB = 2, LW = 16;
  localparam int MAXV = 65535;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rst_n;
  logic                    start_vld, done_vld, lim_we, stats_clr;
  logic [2:0]              start_id, done_id;
  logic [1:0]              start_kind, lim_sel;
  logic [NSTAGE*NSLOT-1:0] stage_stall;
  logic [NARB*NSLOT-1:0]   arb_wait;
  logic [LW-1:0]           lim_val;
  logic                    rpt_vld, viol;
  logic [1:0]              rpt_kind;
  logic [LW-1:0]           rpt_lat;
  logic [NKIND*LW-1:0]     min_lat, max_lat;

  xfer_lat_monitor u_dut (
    .clk(clk), .rst_n(rst_n),
    .start_vld(start_vld), .start_id(start_id), .start_kind(start_kind),
    .done_vld(done_vld), .done_id(done_id),
    .stage_stall(stage_stall), .arb_wait(arb_wait),
    .lim_we(lim_we), .lim_sel(lim_sel), .lim_val(lim_val),
    .stats_clr(stats_clr),
    .rpt_vld(rpt_vld), .rpt_kind(rpt_kind), .rpt_lat(rpt_lat), .viol(viol),
    .min_lat(min_lat), .max_lat(max_lat)
  );

  int  n_chk = 0, n_fail = 0;
  bit  reported = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  // behavioural reference
  bit m_busy [NSLOT];
  int m_start[NSLOT], m_cred[NSLOT], m_kind[NSLOT];
  int m_lim[NKIND], m_min[NKIND], m_max[NKIND];
  int cyc;
  bit e_vld, e_viol;
  int e_lat, e_kind;

  function automatic int pop_for(int id);
    int c = 0;
    for (int s = 0; s < NSTAGE; s++) c += int'(stage_stall[s*NSLOT + id]);
    for (int a = 0; a < NARB; a++)   c += int'(arb_wait[a*NSLOT + id]);
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        m_busy[i] = 0; m_start[i] = 0; m_cred[i] = 0; m_kind[i] = 0;
      end
      for (int k = 0; k < NKIND; k++) begin
        m_lim[k] = MAXV; m_min[k] = MAXV; m_max[k] = 0;
      end
      cyc = 0; e_vld = 0; e_viol = 0; e_lat = 0; e_kind = 0;
    end else begin
      bit any_b, start_ok;
      any_b = 0;
      for (int i = 0; i < NSLOT; i++) any_b |= m_busy[i];
      start_ok = start_vld && !m_busy[start_id];
      e_vld = 0; e_viol = 0;
      for (int i = 0; i < NSLOT; i++)
        if (m_busy[i] && !(done_vld && done_id == 3'(i))) m_cred[i] += pop_for(i);
      if (done_vld && m_busy[done_id]) begin
        int raw, cr, adj;
        raw = cyc - m_start[done_id];
        if (raw > MAXV) raw = MAXV;
        cr = (m_cred[done_id] > MAXV) ? MAXV : m_cred[done_id];
        adj = (raw > cr) ? raw - cr : 0;
        e_vld = 1; e_lat = adj; e_kind = m_kind[done_id];
        e_viol = adj > m_lim[e_kind];
        if (!stats_clr) begin
          if (adj < m_min[e_kind]) m_min[e_kind] = adj;
          if (adj > m_max[e_kind]) m_max[e_kind] = adj;
        end
        m_busy[done_id] = 0;
      end
      if (start_ok) begin
        m_busy[start_id] = 1; m_start[start_id] = cyc;
        m_cred[start_id] = 0; m_kind[start_id] = start_kind;
      end
      if (stats_clr)
        for (int k = 0; k < NKIND; k++) begin m_min[k] = MAXV; m_max[k] = 0; end
      if (lim_we && !any_b) m_lim[lim_sel] = lim_val;
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !reported) begin
      chk("R1", "rpt_vld", rpt_vld, e_vld);
      if (e_vld) begin
        chk("R2", "rpt_lat", rpt_lat, e_lat);
        chk("R5", "rpt_kind", rpt_kind, e_kind);
      end
      chk("R6", "viol", viol, e_viol);
      for (int k = 0; k < NKIND; k++) begin
        chk("R7", "min_lat", min_lat[k*LW +: LW], m_min[k]);
        chk("R7", "max_lat", max_lat[k*LW +: LW], m_max[k]);
      end
    end
  end

  task automatic tick(); @(posedge clk); #5; endtask
  task automatic idle(int n); repeat (n) tick(); endtask

  task automatic do_start(int id, int kind);
    start_vld = 1; start_id = 3'(id); start_kind = 2'(kind);
    tick();
    start_vld = 0;
  endtask

  task automatic do_done(int id);
    done_vld = 1; done_id = 3'(id);
    tick();
    done_vld = 0;
  endtask

  task automatic wr_lim(int k, int v);
    lim_we = 1; lim_sel = 2'(k); lim_val = 16'(v);
    tick();
    lim_we = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual %0d cycles expected completion earlier", 190000);
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; start_vld = 0; done_vld = 0; lim_we = 0; stats_clr = 0;
    start_id = 0; done_id = 0; start_kind = 0; lim_sel = 0; lim_val = 0;
    stage_stall = '0; arb_wait = '0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    tick();
    // R7 reset state
    chk("R7", "reset rpt_vld", rpt_vld, 0);
    chk("R7", "reset min", min_lat[0 +: LW], MAXV);
    chk("R7", "reset max", max_lat[0 +: LW], 0);

    // R1 plain transfer
    do_start(0, xlm_pkg::KIND_PFETCH); idle(4); do_done(0);
    chk("R1", "plain latency", rpt_lat, 5);

    // R2 stage holds
    do_start(1, xlm_pkg::KIND_DACC);
    stage_stall[2*NSLOT + 1] = 1; idle(2); stage_stall = '0; idle(2);
    do_done(1);
    chk("R2", "stage credited", rpt_lat, 3);

    // R3 arbiter waits, two on one edge
    do_start(2, xlm_pkg::KIND_DMA);
    arb_wait[0*NSLOT + 2] = 1; arb_wait[1*NSLOT + 2] = 1; arb_wait[1*NSLOT + 5] = 1;
    tick();
    arb_wait[1*NSLOT + 2] = 0;
    tick();
    arb_wait = '0; idle(2);
    do_done(2);
    chk("R3", "arb credited", rpt_lat, 2);
    chk("R5", "kind dma", rpt_kind, 2);

    // R4 other tags' stalls do not count; R12 floor at zero
    do_start(3, xlm_pkg::KIND_COH);
    do_start(4, xlm_pkg::KIND_COH);
    for (int s = 0; s < NSTAGE; s++) stage_stall[s*NSLOT + 4] = 1;
    for (int a = 0; a < NARB; a++) arb_wait[a*NSLOT + 4] = 1;
    idle(3);
    stage_stall = '0; arb_wait = '0;
    tick();
    do_done(3);
    chk("R4", "foreign stalls ignored", rpt_lat, 6);
    do_done(4);
    chk("R12", "floor at zero", rpt_lat, 0);

    // R6 bound compare
    wr_lim(3, 4);
    do_start(0, 3); idle(4); do_done(0);
    chk("R6", "above bound", viol, 1);
    do_start(0, 3); idle(3); do_done(0);
    chk("R6", "equal to bound", viol, 0);

    // R8 write while busy ignored
    do_start(0, 3);
    wr_lim(3, 100);
    idle(3); do_done(0);
    chk("R8", "busy write ignored", viol, 1);

    // R7 records for class 0
    do_start(5, 0); idle(8); do_done(5);
    do_start(5, 0); idle(2); do_done(5);
    chk("R7", "class0 min", min_lat[0 +: LW], 3);
    chk("R7", "class0 max", max_lat[0 +: LW], 9);

    // R10 repeated start and idle done
    do_start(1, 1); idle(1); do_start(1, 2); idle(1); do_done(1);
    chk("R10", "restart ignored lat", rpt_lat, 4);
    chk("R10", "restart ignored kind", rpt_kind, 1);
    do_done(6);
    chk("R10", "idle done silent", rpt_vld, 0);

    // R9 clear
    stats_clr = 1; tick(); stats_clr = 0;
    chk("R9", "clear min", min_lat[0 +: LW], MAXV);
    chk("R9", "clear max", max_lat[3*LW +: LW], 0);

    // R11 saturation
    do_start(0, 2); do_start(1, 2);
    for (int s = 0; s < NSTAGE; s++) stage_stall[s*NSLOT + 1] = 1;
    for (int a = 0; a < NARB; a++) arb_wait[a*NSLOT + 1] = 1;
    idle(70000);
    stage_stall = '0; arb_wait = '0;
    do_done(0);
    chk("R11", "flight time saturates", rpt_lat, MAXV);
    chk("R6", "saturated equals default bound", viol, 0);
    do_done(1);
    chk("R11", "credit saturates", rpt_lat, 0);

    idle(3);
    summary();
    $finish;
  end

endmodule